// File: doc/BRIEF.md
# Configuration Register Bank with Per-Bit Write Semantics

This block is a small bank of host-visible configuration registers. The host issues one access per cycle. Each access carries a dword index, a 32-bit write bus and four byte enables, so byte, word and dword transfers all work. Lane 0 (`acc_be[0]`, `acc_wdata[7:0]`) is the lowest byte address and holds the least significant byte of a register.

Every implemented bit has a fixed write rule: fixed or hardware-driven read-only, plain read/write, write-one-to-clear, writable once per reset, or read/write that freezes behind a lock bit. Hardware event pulses set status bits. Read data and a completion strobe appear one cycle after the access. Locations that have no register complete normally, read as zero and ignore writes.

Register map by dword index:

| Index | Register | Contents |
|---|---|---|
| 0 | Identity | fixed constant `ID_VALUE`, read-only |
| 1 | Control | bits [15:0] read/write, reset `0x0010`; bits [31:16] reserved |
| 2 | Status | bits [7:0] write-one-to-clear, set by `hw_evt`; bits [23:16] read-only mirror of `hw_stat`; the rest reserved |
| 3 | Once | byte lanes 0 and 1 write-once; lanes 2 and 3 reserved |
| 4 | Guard | bits [23:0] read/write, bit 31 lock, reset `0x000000A5`; bits [30:24] reserved |
| 5 to 15 | — | unimplemented |

The internal reset is asserted at once and released two clock edges after `rst_n` rises.

Top module: `cfgbank_top`

## Requirements
- R1: After reset, the registers read as follows: index 0 = `0x5A3C1E07`, index 1 = `0x00000010`, index 2 = `hw_stat` in bits [23:16] with all other bits zero, index 3 = `0`, index 4 = `0x000000A5`. `acc_done` is low while the bank is idle.
- R2: Writes to the identity register and to the `hw_stat` field of index 2 have no effect. That field always reads the current value of `hw_stat`.
- R3: A write changes only the byte lanes whose `acc_be` bit is 1. Lanes whose enable is 0 keep their value, whatever their write rule.
- R4: In status bits [7:0] of index 2, writing 1 clears the bit and writing 0 leaves it unchanged. A `hw_evt` bit that is high for one cycle sets the matching bit.
- R5: When a `hw_evt` bit and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Each write-once lane of index 3 takes the first write that enables it after reset. From then on it ignores writes, and lanes that have not yet been written stay writable.
- R7: Once bit 31 of index 4 is 1, later writes leave the whole register unchanged. The write that sets bit 31 also updates bits [23:0] in the same cycle.
- R8: Any access to indices 5 to 15 completes, with `acc_done` high one cycle later. A read there returns zero, and a write there changes no register.
- R9: Reserved bits of implemented registers read as zero even after all-ones writes.
- R10: Byte lane n maps `acc_wdata[8n+7:8n]` to register bits [8n+7:8n], in little-endian order.
- R11: A reset clears all write-once flags and the lock bit, and returns every register to its default value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (4) | Dword index |
| acc_wdata | input | 32 | Write data |
| acc_be | input | 4 | Byte enables, bit n = lane n |
| acc_rdata | output | 32 | Read data, valid with `acc_done` |
| acc_done | output | 1 | Access completed, one cycle after `acc_vld` |
| hw_evt | input | EVT_W (8) | Hardware set pulses for the status bits |
| hw_stat | input | STAT_W (8) | Hardware value shown in the status read-only field |
| ctrl_out | output | 16 | Control register contents |
| once_out | output | 16 | Write-once register contents |
| guard_out | output | 24 | Guard register data field |
| guard_locked | output | 1 | Guard lock bit |

## Verification
The bench aims at the cycle where a hardware set meets a software clear. A design with the wrong priority drops the event. It also writes a write-once lane a second time with a wider byte mask. A design that tracks once-use per register, and not per lane, would either lock the untouched lane or reopen the used one. The lock test checks that the write which sets the lock still updates its data field, and that everything after it is refused; a lock checked one cycle too early or too late fails there. Partial byte-enable writes, reserved-index accesses and a second reset catch lane slips, aliasing onto real registers, and once or lock state that survives reset.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LANES = DW / 8;

  localparam int unsigned IDX_ID    = 0;
  localparam int unsigned IDX_CTRL  = 1;
  localparam int unsigned IDX_STAT  = 2;
  localparam int unsigned IDX_ONCE  = 3;
  localparam int unsigned IDX_GUARD = 4;
  localparam int unsigned NUM_IMPL  = 5;

  // expand byte enables into a per-bit mask
  function automatic logic [DW-1:0] lane_bits(input logic [LANES-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/cfgbank_merge.sv
module cfgbank_merge
  import cfgbank_pkg::*;
#(
  parameter logic [DW-1:0] RW_MASK  = '0,
  parameter logic [DW-1:0] W1C_MASK = '0
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] lane_mask,
  input  logic          wen,
  input  logic [DW-1:0] set_bits,
  output logic [DW-1:0] nxt
);
  logic [DW-1:0] act;
  logic [DW-1:0] rw_sel;
  logic [DW-1:0] clr_sel;

  always_comb begin
    act     = lane_mask & {DW{wen}};
    rw_sel  = act & RW_MASK;
    clr_sel = act & W1C_MASK & wdata;
    nxt     = (cur & ~rw_sel) | (wdata & rw_sel);
    nxt     = nxt & ~clr_sel;
    // hardware set applied last: set beats clear
    nxt     = nxt | (set_bits & W1C_MASK);
  end
endmodule

// File: rtl/cfgbank_once.sv
module cfgbank_once #(
  parameter int unsigned NLANE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wen,
  input  logic [NLANE-1:0] be,
  output logic [NLANE-1:0] open
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic used_q;
    logic used_d;
    logic used_en;

    always_comb begin
      used_en = wen & be[g] & ~used_q;
      used_d  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       used_q <= 1'b0;
      else if (used_en) used_q <= used_d;
    end

    assign open[g] = ~used_q;
  end
endmodule

// File: rtl/cfgbank_rdmux.sv
module cfgbank_rdmux
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NREG   = 5
) (
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [ADDR_W-1:0]       addr,
  output logic [DW-1:0]           dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i)) dout = regs[i];
    end
  end
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int unsigned     ADDR_W     = 4,
  parameter int unsigned     EVT_W      = 8,
  parameter int unsigned     STAT_W     = 8,
  parameter int unsigned     ONCE_BYTES = 2,
  parameter int unsigned     LOCK_BIT   = 31,
  parameter logic [DW-1:0]   ID_VALUE   = 32'h5A3C_1E07,
  parameter logic [DW-1:0]   CTRL_RST   = 32'h0000_0010,
  parameter logic [DW-1:0]   CTRL_MASK  = 32'h0000_FFFF,
  parameter logic [DW-1:0]   GUARD_RST  = 32'h0000_00A5,
  parameter logic [DW-1:0]   GUARD_MASK = 32'h80FF_FFFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_vld,
  input  logic                    acc_wr,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [DW-1:0]           acc_wdata,
  input  logic [LANES-1:0]        acc_be,
  output logic [DW-1:0]           acc_rdata,
  output logic                    acc_done,
  input  logic [EVT_W-1:0]        hw_evt,
  input  logic [STAT_W-1:0]       hw_stat,
  output logic [15:0]             ctrl_out,
  output logic [ONCE_BYTES*8-1:0] once_out,
  output logic [23:0]             guard_out,
  output logic                    guard_locked
);
  localparam logic [DW-1:0] EVT_MASK  = DW'((64'd1 << EVT_W) - 1);
  localparam logic [DW-1:0] ONCE_MASK = DW'((64'd1 << (ONCE_BYTES*8)) - 1);
  localparam int unsigned   STAT_LSB  = 16;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // access decode
  logic          is_wr;
  logic          is_rd;
  logic          wr_ctrl;
  logic          wr_stat;
  logic          wr_once;
  logic          wr_guard;
  logic [DW-1:0] lane_m;

  always_comb begin
    is_wr    = acc_vld & acc_wr;
    is_rd    = acc_vld & ~acc_wr;
    wr_ctrl  = is_wr & (acc_addr == ADDR_W'(IDX_CTRL));
    wr_stat  = is_wr & (acc_addr == ADDR_W'(IDX_STAT));
    wr_once  = is_wr & (acc_addr == ADDR_W'(IDX_ONCE));
    wr_guard = is_wr & (acc_addr == ADDR_W'(IDX_GUARD));
    lane_m   = lane_bits(acc_be);
  end

  // storage
  logic [DW-1:0] ctrl_q,  ctrl_d;
  logic [DW-1:0] stat_q,  stat_d;
  logic [DW-1:0] once_q,  once_d;
  logic [DW-1:0] guard_q, guard_d;
  logic [DW-1:0] rd_q,    rd_d;
  logic          done_q;
  logic          stat_en;

  cfgbank_merge #(.RW_MASK(CTRL_MASK), .W1C_MASK('0)) u_ctrl (
    .cur(ctrl_q), .wdata(acc_wdata), .lane_mask(lane_m), .wen(wr_ctrl),
    .set_bits('0), .nxt(ctrl_d)
  );

  logic [DW-1:0] evt_bits;
  always_comb begin
    evt_bits            = '0;
    evt_bits[EVT_W-1:0] = hw_evt;
    stat_en             = wr_stat | (|hw_evt);
  end

  cfgbank_merge #(.RW_MASK('0), .W1C_MASK(EVT_MASK)) u_stat (
    .cur(stat_q), .wdata(acc_wdata), .lane_mask(lane_m), .wen(wr_stat),
    .set_bits(evt_bits), .nxt(stat_d)
  );

  // write-once lanes
  logic [ONCE_BYTES-1:0] once_open;
  logic [LANES-1:0]      be_once;
  logic [DW-1:0]         once_lane_m;

  cfgbank_once #(.NLANE(ONCE_BYTES)) u_once_trk (
    .clk(clk), .rst_n(rst_int_n), .wen(wr_once),
    .be(acc_be[ONCE_BYTES-1:0]), .open(once_open)
  );

  always_comb begin
    be_once                   = '0;
    be_once[ONCE_BYTES-1:0]   = acc_be[ONCE_BYTES-1:0] & once_open;
    once_lane_m               = lane_bits(be_once);
  end

  cfgbank_merge #(.RW_MASK(ONCE_MASK), .W1C_MASK('0)) u_once (
    .cur(once_q), .wdata(acc_wdata), .lane_mask(once_lane_m), .wen(wr_once),
    .set_bits('0), .nxt(once_d)
  );

  // lock-protected register: lock is sampled from the stored value
  logic guard_wen;
  assign guard_wen = wr_guard & ~guard_q[LOCK_BIT];

  cfgbank_merge #(.RW_MASK(GUARD_MASK), .W1C_MASK('0)) u_guard (
    .cur(guard_q), .wdata(acc_wdata), .lane_mask(lane_m), .wen(guard_wen),
    .set_bits('0), .nxt(guard_d)
  );

  // read path
  logic [DW-1:0]               stat_view;
  logic [NUM_IMPL-1:0][DW-1:0] rd_vec;
  logic [DW-1:0]               rd_sel;

  always_comb begin
    stat_view                      = stat_q;
    stat_view[STAT_LSB +: STAT_W]  = hw_stat;
    rd_vec[IDX_ID]                 = ID_VALUE;
    rd_vec[IDX_CTRL]               = ctrl_q;
    rd_vec[IDX_STAT]               = stat_view;
    rd_vec[IDX_ONCE]               = once_q;
    rd_vec[IDX_GUARD]              = guard_q;
  end

  cfgbank_rdmux #(.ADDR_W(ADDR_W), .NREG(NUM_IMPL)) u_rdmux (
    .regs(rd_vec), .addr(acc_addr), .dout(rd_sel)
  );

  assign rd_d = rd_sel;

  // register processes with explicit enables
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctrl_q <= CTRL_RST & CTRL_MASK;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   once_q <= '0;
    else if (wr_once) once_q <= once_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)     guard_q <= GUARD_RST & GUARD_MASK;
    else if (guard_wen) guard_q <= guard_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rd_q <= '0;
    else if (is_rd) rd_q <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) done_q <= 1'b0;
    else            done_q <= acc_vld;
  end

  assign acc_rdata    = rd_q;
  assign acc_done     = done_q;
  assign ctrl_out     = ctrl_q[15:0];
  assign once_out     = once_q[ONCE_BYTES*8-1:0];
  assign guard_out    = guard_q[23:0];
  assign guard_locked = guard_q[LOCK_BIT];
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned EVT_W      = 8,
  parameter int unsigned ONCE_BYTES = 2,
  parameter int unsigned NREG       = 5,
  parameter int unsigned LOCK_BIT   = 31
) (
  input logic                    clk,
  input logic                    rst_int_n,
  input logic                    acc_vld,
  input logic                    acc_wr,
  input logic [ADDR_W-1:0]       acc_addr,
  input logic                    acc_done,
  input logic [31:0]             acc_rdata,
  input logic [EVT_W-1:0]        hw_evt,
  input logic [31:0]             stat_q,
  input logic [31:0]             guard_q,
  input logic [31:0]             once_q,
  input logic [ONCE_BYTES-1:0]   once_open
);
  // R8
  access_done_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_vld |=> acc_done);

  // R8
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_vld && !acc_wr && (acc_addr >= ADDR_W'(NREG))) |=> (acc_rdata == 32'd0));

  // R5
  evt_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|hw_evt) |=> ((stat_q[EVT_W-1:0] & $past(hw_evt)) == $past(hw_evt)));

  // R7
  lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    guard_q[LOCK_BIT] |=> $stable(guard_q));

  for (genvar k = 0; k < ONCE_BYTES; k++) begin : g_once
    // R6
    once_lane_frozen_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      !once_open[k] |=> $stable(once_q[k*8 +: 8]));
  end
endmodule

bind cfgbank_top cfgbank_chk #(
  .ADDR_W(ADDR_W), .EVT_W(EVT_W), .ONCE_BYTES(ONCE_BYTES),
  .NREG(cfgbank_pkg::NUM_IMPL), .LOCK_BIT(LOCK_BIT)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .acc_done(acc_done), .acc_rdata(acc_rdata),
  .hw_evt(hw_evt), .stat_q(stat_q), .guard_q(guard_q), .once_q(once_q),
  .once_open(once_open)
);

// File: tb/sim_cfgbank_top.sv
module sim_cfgbank_top;
  logic        clk;
  logic        rst_n;
  logic        acc_vld;
  logic        acc_wr;
  logic [3:0]  acc_addr;
  logic [31:0] acc_wdata;
  logic [3:0]  acc_be;
  logic [31:0] acc_rdata;
  logic        acc_done;
  logic [7:0]  hw_evt;
  logic [7:0]  hw_stat;
  logic [15:0] ctrl_out;
  logic [15:0] once_out;
  logic [23:0] guard_out;
  logic        guard_locked;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 0;

  cfgbank_top u0 (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_be(acc_be),
    .acc_rdata(acc_rdata), .acc_done(acc_done), .hw_evt(hw_evt),
    .hw_stat(hw_stat), .ctrl_out(ctrl_out), .once_out(once_out),
    .guard_out(guard_out), .guard_locked(guard_locked)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d; acc_be = be;
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b0; acc_be = 4'h0; acc_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic done);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = 1'b0; acc_addr = a; acc_be = 4'hF;
    @(negedge clk);
    acc_vld = 1'b0; acc_be = 4'h0;
    d    = acc_rdata;
    done = acc_done;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic        dn;
    rd(a, d, dn);
    check(req, d, exp);
  endtask

  // R1: reset defaults
  task automatic t_reset();
    check("R1 done idle", {31'd0, acc_done}, 32'd0);
    rd_chk("R1 id",    4'd0, 32'h5A3C_1E07);
    rd_chk("R1 ctrl",  4'd1, 32'h0000_0010);
    rd_chk("R1 stat",  4'd2, 32'h003C_0000);
    rd_chk("R1 once",  4'd3, 32'h0000_0000);
    rd_chk("R1 guard", 4'd4, 32'h0000_00A5);
  endtask

  // R2: read-only identity and hardware field
  task automatic t_readonly();
    wr(4'd0, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R2 id after write", 4'd0, 32'h5A3C_1E07);
    wr(4'd2, 32'h00FF_0000, 4'hF);
    rd_chk("R2 hw field after write", 4'd2, 32'h003C_0000);
    hw_stat = 8'h5A;
    rd_chk("R2 hw field live", 4'd2, 32'h005A_0000);
    hw_stat = 8'h3C;
  endtask

  // R3 R10 R9: lanes and reserved bits
  task automatic t_rw_lanes();
    wr(4'd1, 32'hAABB_CCDD, 4'b0001);
    rd_chk("R10 lane0 to low byte", 4'd1, 32'h0000_00DD);
    wr(4'd1, 32'h1122_3344, 4'b0010);
    rd_chk("R3 lane1 only", 4'd1, 32'h0000_33DD);
    check("R3 ctrl_out", {16'd0, ctrl_out}, 32'h0000_33DD);
    wr(4'd1, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R9 reserved ctrl bits zero", 4'd1, 32'h0000_FFFF);
    wr(4'd4, 32'h7F00_0000, 4'b1000);
    rd_chk("R9 reserved guard bits zero", 4'd4, 32'h0000_00A5);
  endtask

  // R4: write-one-to-clear and event set
  task automatic t_w1c();
    @(negedge clk); hw_evt = 8'hF0;
    @(negedge clk); hw_evt = 8'h00;
    rd_chk("R4 event sets", 4'd2, 32'h003C_00F0);
    wr(4'd2, 32'h0000_0030, 4'b0001);
    rd_chk("R4 one clears", 4'd2, 32'h003C_00C0);
    wr(4'd2, 32'h0000_0000, 4'b0001);
    rd_chk("R4 zero keeps", 4'd2, 32'h003C_00C0);
    wr(4'd2, 32'h0000_00C0, 4'b0000);
    rd_chk("R3 disabled lane no clear", 4'd2, 32'h003C_00C0);
  endtask

  // R5: set beats clear
  task automatic t_setwins();
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = 1'b1; acc_addr = 4'd2; acc_wdata = 32'h0000_00C0; acc_be = 4'b0001;
    hw_evt = 8'h80;
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b0; acc_be = 4'h0; hw_evt = 8'h00;
    rd_chk("R5 set wins, other bit cleared", 4'd2, 32'h003C_0080);
  endtask

  // R6: write-once per lane
  task automatic t_once();
    wr(4'd3, 32'h0000_1234, 4'b0001);
    rd_chk("R6 first lane0 write", 4'd3, 32'h0000_0034);
    wr(4'd3, 32'h0000_ABCD, 4'b0011);
    rd_chk("R6 lane0 frozen, lane1 first", 4'd3, 32'h0000_AB34);
    wr(4'd3, 32'h0000_5500, 4'b0010);
    rd_chk("R6 lane1 frozen", 4'd3, 32'h0000_AB34);
    wr(4'd3, 32'hFFFF_0000, 4'b1100);
    rd_chk("R9 once reserved lanes", 4'd3, 32'h0000_AB34);
  endtask

  // R7: lock
  task automatic t_lock();
    wr(4'd4, 32'h8012_3456, 4'hF);
    rd_chk("R7 locking write updates data", 4'd4, 32'h8012_3456);
    check("R7 locked flag", {31'd0, guard_locked}, 32'd1);
    wr(4'd4, 32'h0000_0000, 4'hF);
    rd_chk("R7 locked ignores write", 4'd4, 32'h8012_3456);
  endtask

  // R8: unimplemented locations
  task automatic t_reserved();
    logic [31:0] d;
    logic        dn;
    rd(4'd7, d, dn);
    check("R8 reserved read zero", d, 32'd0);
    check("R8 reserved read completes", {31'd0, dn}, 32'd1);
    wr(4'd9, 32'hFFFF_FFFF, 4'hF);
    check("R8 reserved write completes", {31'd0, acc_done}, 32'd1);
    rd_chk("R8 reserved write no effect", 4'd9, 32'd0);
    rd_chk("R8 ctrl untouched", 4'd1, 32'h0000_FFFF);
    rd_chk("R8 index 15 zero", 4'd15, 32'd0);
  endtask

  // R11: reset clears once flags and lock
  task automatic t_rereset();
    do_reset();
    rd_chk("R11 once default", 4'd3, 32'd0);
    rd_chk("R11 guard default", 4'd4, 32'h0000_00A5);
    rd_chk("R11 stat default", 4'd2, 32'h003C_0000);
    wr(4'd3, 32'h0000_0077, 4'b0001);
    rd_chk("R11 once writable again", 4'd3, 32'h0000_0077);
    wr(4'd4, 32'h0000_0001, 4'b0001);
    rd_chk("R11 guard unlocked", 4'd4, 32'h0000_0001);
  endtask

  initial begin
    rst_n = 1'b0; acc_vld = 1'b0; acc_wr = 1'b0; acc_addr = '0;
    acc_wdata = '0; acc_be = '0; hw_evt = '0; hw_stat = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_readonly();
    t_rw_lanes();
    t_w1c();
    t_setwins();
    t_once();
    t_lock();
    t_reserved();
    t_rereset();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule